// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block is the parallel programming port of a small on-chip code flash. An external programmer presents a 12-bit address, split over a low byte and a high nibble, a data byte and a 4-bit mode code, and then strobes an active-low program pulse. The controller decodes the mode and performs one of these operations: byte programming, verify readback, signature readback, lock-bit programming or whole-array erase. The flash cells are modelled as a register array. High-voltage generation is outside the block; a single `hv_en` flag stands in for it.

Byte and lock writes run on an internal timer once the pulse has been seen. The programmer can follow a write in two ways. The `rdy` output is low while the write runs. A verify read of the address being written returns the written bit 7 inverted until the write finishes. Erase is started by the width of the pulse: it happens only once the pulse has stayed low long enough. Lock bits hide the array from verify reads. Lock bit 1 also freezes the external-access level that was present during reset.

Top module: `flash_prog_ctrl`

## Requirements
- R1: The cell address is `{addr_hi, addr_lo}` and covers 000h to FFFh. `addr_hi` supplies bits 11:8.
- R2: In mode 4'b0111, a falling edge of `prog_n` starts a byte write. When the write completes, the stored byte becomes the old value AND `data_in`, so bits can only go from 1 to 0.
- R3: `rdy` goes low after the first clock edge that samples `prog_n` low for a write that is accepted. It stays low for exactly WRITE_CYCLES clock cycles and then goes high.
- R4: A falling edge of `prog_n` while `rdy` is low is ignored. It writes nothing and does not lengthen the busy time.
- R5: With HV_MODE=1, a program pulse while `hv_en` is low is ignored. `rdy` stays high and the array does not change.
- R6: While a byte write is busy, a verify read of its address returns bit 7 as the inverse of bit 7 of the data being written.
- R7: In mode 4'b0001, holding `prog_n` low for ERASE_CYCLES consecutive clock edges sets every byte to FFh and clears all lock bits. A shorter low pulse has no effect.
- R8: In mode 4'b0000, addresses 030h, 031h and 032h read 1Eh, 51h, and FFh (HV_MODE=1) or 05h (HV_MODE=0). Every other address reads FFh.
- R9: In mode 4'b0011, a verify read returns the stored byte while no lock bit is set. It returns FFh otherwise. Read data is registered, so it appears one clock after the address and mode. `data_oe` is high exactly in modes 4'b0011 and 4'b0000.
- R10: Modes 4'b1111 and 4'b1100 program lock bit 1 and lock bit 2. These writes run the same timed cycle, with `rdy` low.
- R11: While lock bit 1 is clear, `ea_out` follows `ext_access`. While it is set, `ea_out` holds the `ext_access` level sampled during the last reset.
- R12: Reset (synchronous, active low) leaves `rdy` high and `data_out` at 00h. Array contents and lock bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_lo | input | 8 | Address bits 7:0 |
| addr_hi | input | 4 | Address bits 11:8 |
| data_in | input | 8 | Byte to program |
| mode_sel | input | 4 | Operation code |
| prog_n | input | 1 | Active-low program pulse |
| hv_en | input | 1 | Programming voltage present |
| ext_access | input | 1 | External-access strap level |
| data_out | output | 8 | Registered read data |
| data_oe | output | 1 | Read data valid and driven |
| rdy | output | 1 | High when no write is in progress |
| ea_out | output | 1 | Effective external-access level |

## Verification
The hardest state to reach from the ports is an in-flight write, because the polling value and the rejection of a second pulse exist only during that window. The stimulus counts clock edges from the first one that samples the pulse low. Within that window it switches the mode pins to verify, or fires a second pulse at another address. It then samples `rdy` on the last busy cycle and on the first ready cycle. The effect of lock bit 1 on the external-access level needs another sequence: program the lock bit, apply a reset with the strap high, then drop the strap.

// File: rtl/fpc_pkg.sv
// Shared types and constants for the flash programming controller.
// Assumes a 4-bit mode code; any unlisted code decodes to idle.
package fpc_pkg;
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_WRITE,
        OP_VERIFY,
        OP_ERASE,
        OP_SIG,
        OP_LOCK1,
        OP_LOCK2,
        OP_LOCK3
    } fpc_op_e;

    localparam logic [3:0] MODE_WRITE  = 4'b0111;
    localparam logic [3:0] MODE_VERIFY = 4'b0011;
    localparam logic [3:0] MODE_ERASE  = 4'b0001;
    localparam logic [3:0] MODE_SIG    = 4'b0000;
    localparam logic [3:0] MODE_LOCK1  = 4'b1111;
    localparam logic [3:0] MODE_LOCK2  = 4'b1100;
    localparam logic [3:0] MODE_LOCK3  = 4'b1010;

    localparam logic [7:0] SIG_VENDOR  = 8'h1E;
    localparam logic [7:0] SIG_PART    = 8'h51;
    localparam logic [7:0] SIG_HV      = 8'hFF;
    localparam logic [7:0] SIG_LV      = 8'h05;
    localparam int         SIG_BASE    = 'h30;
endpackage

// File: rtl/fpc_mode_decode.sv
// Mode decoder: turns the 4 mode pins into one operation code.
// Purely combinational; assumes the pins are stable around the program pulse.
module fpc_mode_decode
    import fpc_pkg::*;
(
    input  logic [3:0] mode_pins,
    output fpc_op_e    op
);
    // Map each documented code to its operation, everything else to idle.
    always_comb begin
        unique case (mode_pins)
            MODE_WRITE:  op = OP_WRITE;
            MODE_VERIFY: op = OP_VERIFY;
            MODE_ERASE:  op = OP_ERASE;
            MODE_SIG:    op = OP_SIG;
            MODE_LOCK1:  op = OP_LOCK1;
            MODE_LOCK2:  op = OP_LOCK2;
            MODE_LOCK3:  op = OP_LOCK3;
            default:     op = OP_IDLE;
        endcase
    end
endmodule

// File: rtl/fpc_cycle_timer.sv
// Self-timed write cycle: once started it stays busy for CYCLES clocks.
// Starts are refused while busy. done marks the last busy cycle.
module fpc_cycle_timer #(
    parameter int CYCLES = 187500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] remain;

    // Load the count on an accepted start and run it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            remain <= CNT_W'(CYCLES - 1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    assign done = busy && (remain == '0);
endmodule

// File: rtl/fpc_erase_gauge.sv
// Measures how long the erase request has been held.
// Emits one strobe per low pulse once it has lasted HOLD_CYCLES edges.
module fpc_erase_gauge #(
    parameter int HOLD_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic erase_stb
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] held;
    logic             fired;

    // Count consecutive held edges and fire once on reaching the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !hold) begin
            held      <= '0;
            fired     <= 1'b0;
            erase_stb <= 1'b0;
        end else begin
            erase_stb <= 1'b0;
            if (!fired) begin
                if (held == CNT_W'(HOLD_CYCLES - 1)) begin
                    erase_stb <= 1'b1;
                    fired     <= 1'b1;
                end else begin
                    held <= held + 1'b1;
                end
            end
        end
    end

    // R7: an erase strobe only ever follows a cycle in which the request was held.
    a_r7_strobe_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |-> $past(hold));
endmodule

// File: rtl/fpc_flash_array.sv
// Cell array, lock bits and the latch holding the write in flight.
// Cells and lock bits are non-volatile: reset does not touch them, and they
// are undefined until the first chip erase.
module fpc_flash_array
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  fpc_op_e           start_op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    input  logic              busy,
    input  logic              commit,
    input  logic              erase,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_byte,
    output logic [2:0]        locks,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [DATA_W-1:0] pend_data,
    output logic              pend_is_byte
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    fpc_op_e           pend_op;

    // Capture the operation accepted by the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_op   <= OP_IDLE;
            pend_addr <= '0;
            pend_data <= '0;
        end else if (start && !busy) begin
            pend_op   <= start_op;
            pend_addr <= start_addr;
            pend_data <= start_data;
        end
    end

    assign pend_is_byte = (pend_op == OP_WRITE);

    // Update cells and lock bits on erase or at the end of a timed write.
    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
            locks <= 3'b000;
        end else if (commit) begin
            unique case (pend_op)
                OP_WRITE: cells[pend_addr] <= cells[pend_addr] & pend_data;
                OP_LOCK1: locks[0] <= 1'b1;
                OP_LOCK2: locks[1] <= 1'b1;
                OP_LOCK3: locks[2] <= 1'b1;
                default:  ;
            endcase
        end
    end

    assign rd_byte = cells[rd_addr];

    // R2: after a byte commit the cell has no 1 where the written data had a 0.
    a_r2_and_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(commit) && $past(pend_op == OP_WRITE) && !$past(erase)
        |-> ((cells[$past(pend_addr)] & ~$past(pend_data)) == '0));

    // R4: the latched operation holds still for the whole busy window.
    a_r4_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !commit |=> $stable(pend_addr) && $stable(pend_data) && $stable(pend_op));
endmodule

// File: rtl/fpc_read_port.sv
// Registered read path: verify data, status polling and signature bytes.
// Assumes mode and address settle one clock before the value is sampled.
module fpc_read_port
    import fpc_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 8,
    parameter bit HV_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fpc_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rd_byte,
    input  logic [2:0]        locks,
    input  logic              busy,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [DATA_W-1:0] pend_data,
    input  logic              pend_is_byte,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    localparam int MSB = DATA_W - 1;

    logic              poll_hit;
    logic              hidden;
    logic [DATA_W-1:0] sig_val;

    assign poll_hit = busy && pend_is_byte && (addr == pend_addr);
    assign hidden   = |locks;
    assign data_oe  = (op == OP_VERIFY) || (op == OP_SIG);

    // Pick the signature byte for the current address.
    always_comb begin
        if (addr == ADDR_W'(SIG_BASE))          sig_val = DATA_W'(SIG_VENDOR);
        else if (addr == ADDR_W'(SIG_BASE + 1)) sig_val = DATA_W'(SIG_PART);
        else if (addr == ADDR_W'(SIG_BASE + 2)) sig_val = HV_MODE ? DATA_W'(SIG_HV) : DATA_W'(SIG_LV);
        else                                    sig_val = '1;
    end

    // Register the value the current mode selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
        end else begin
            unique case (op)
                OP_VERIFY: begin
                    if (poll_hit)    data_out <= {~pend_data[MSB], rd_byte[MSB-1:0]};
                    else if (hidden) data_out <= '1;
                    else             data_out <= rd_byte;
                end
                OP_SIG:  data_out <= sig_val;
                default: data_out <= '0;
            endcase
        end
    end

    // R9: a locked verify read outside a poll always yields all ones.
    a_r9_lock_hides: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op == OP_VERIFY) && $past(hidden) && !$past(poll_hit)
        |-> (data_out == '1));
endmodule

// File: rtl/flash_prog_ctrl.sv
// Parallel programming controller for an on-chip code flash.
// Detects the program pulse, gates it on mode, supply and busy state,
// and ties the timer, erase gauge, array and read port together.
// Assumes prog_n is synchronous to clk.
module flash_prog_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_LO_W    = 8,
    parameter int ADDR_HI_W    = 4,
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 187500,
    parameter int ERASE_CYCLES = 1250000,
    parameter bit HV_MODE      = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_LO_W-1:0] addr_lo,
    input  logic [ADDR_HI_W-1:0] addr_hi,
    input  logic [DATA_W-1:0]    data_in,
    input  logic [3:0]           mode_sel,
    input  logic                 prog_n,
    input  logic                 hv_en,
    input  logic                 ext_access,
    output logic [DATA_W-1:0]    data_out,
    output logic                 data_oe,
    output logic                 rdy,
    output logic                 ea_out
);
    localparam int ADDR_W = ADDR_LO_W + ADDR_HI_W;

    fpc_op_e           op;
    logic [ADDR_W-1:0] addr;
    logic              prog_q;
    logic              prog_fall;
    logic              hv_ok;
    logic              is_write_op;
    logic              start;
    logic              busy;
    logic              done;
    logic              erase_hold;
    logic              erase_stb;
    logic [DATA_W-1:0] rd_byte;
    logic [2:0]        locks;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;
    logic              pend_is_byte;
    logic              ea_q;

    assign addr = {addr_hi, addr_lo};

    fpc_mode_decode u_dec (
        .mode_pins (mode_sel),
        .op        (op)
    );

    // Remember the previous pulse level to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prog_q <= 1'b1;
        else        prog_q <= prog_n;
    end

    assign prog_fall   = prog_q && !prog_n;
    assign hv_ok       = !HV_MODE || hv_en;
    assign is_write_op = (op == OP_WRITE) || (op == OP_LOCK1) ||
                         (op == OP_LOCK2) || (op == OP_LOCK3);
    assign start       = prog_fall && hv_ok && is_write_op && !busy;
    assign erase_hold  = !prog_n && (op == OP_ERASE) && hv_ok && !busy;

    fpc_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    fpc_erase_gauge #(.HOLD_CYCLES(ERASE_CYCLES)) u_gauge (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (erase_hold),
        .erase_stb (erase_stb)
    );

    fpc_flash_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_op     (op),
        .start_addr   (addr),
        .start_data   (data_in),
        .busy         (busy),
        .commit       (done),
        .erase        (erase_stb),
        .rd_addr      (addr),
        .rd_byte      (rd_byte),
        .locks        (locks),
        .pend_addr    (pend_addr),
        .pend_data    (pend_data),
        .pend_is_byte (pend_is_byte)
    );

    fpc_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HV_MODE(HV_MODE)) u_read (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op),
        .addr         (addr),
        .rd_byte      (rd_byte),
        .locks        (locks),
        .busy         (busy),
        .pend_addr    (pend_addr),
        .pend_data    (pend_data),
        .pend_is_byte (pend_is_byte),
        .data_out     (data_out),
        .data_oe      (data_oe)
    );

    // Sample the external-access strap while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) ea_q <= ext_access;
    end

    assign ea_out = locks[0] ? ea_q : ext_access;
    assign rdy    = !busy;

    // R3: ready only drops after an edge that saw the pulse low.
    a_r3_rdy_falls_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(!prog_n));

    // R5: in high-voltage mode a write is only accepted with the supply flag up.
    a_r5_hv_required: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> (!HV_MODE || $past(hv_en)));
endmodule

// File: tb/flash_prog_ctrl_test.sv
module flash_prog_ctrl_test;
    localparam int W = 40;
    localparam int E = 100;

    localparam logic [3:0] M_IDLE = 4'b1000;
    localparam logic [3:0] M_WR   = 4'b0111;
    localparam logic [3:0] M_VER  = 4'b0011;
    localparam logic [3:0] M_ERA  = 4'b0001;
    localparam logic [3:0] M_SIG  = 4'b0000;
    localparam logic [3:0] M_L1   = 4'b1111;
    localparam logic [3:0] M_L2   = 4'b1100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_lo = '0;
    logic [3:0] addr_hi = '0;
    logic [7:0] data_in = '0;
    logic [3:0] mode_sel = M_IDLE;
    logic       prog_n = 1'b1;
    logic       hv_en = 1'b1;
    logic       ext_access = 1'b0;
    logic [7:0] data_out;
    logic       data_oe;
    logic       rdy;
    logic       ea_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_prog_ctrl #(
        .WRITE_CYCLES (W),
        .ERASE_CYCLES (E),
        .HV_MODE      (1'b1)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_lo    (addr_lo),
        .addr_hi    (addr_hi),
        .data_in    (data_in),
        .mode_sel   (mode_sel),
        .prog_n     (prog_n),
        .hv_en      (hv_en),
        .ext_access (ext_access),
        .data_out   (data_out),
        .data_oe    (data_oe),
        .rdy        (rdy),
        .ea_out     (ea_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic set_addr(input logic [11:0] a);
        {addr_hi, addr_lo} = a;
    endtask

    // Read one byte: mode/address set at a negedge, registered at the next posedge.
    task automatic read_byte(input logic [3:0] m, input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        mode_sel = m;
        set_addr(a);
        @(negedge clk);
        d = data_out;
    endtask

    task automatic prog_cycle(input int low_edges);
        @(negedge clk);
        prog_n = 1'b0;
        repeat (low_edges) @(negedge clk);
        prog_n = 1'b1;
    endtask

    task automatic write_byte(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        mode_sel = M_WR;
        set_addr(a);
        data_in = d;
        hv_en = 1'b1;
        prog_cycle(3);
        repeat (W + 4) @(negedge clk);
    endtask

    task automatic do_erase(input int low_edges);
        @(negedge clk);
        mode_sel = M_ERA;
        hv_en = 1'b1;
        prog_cycle(low_edges);
        repeat (3) @(negedge clk);
        mode_sel = M_IDLE;
    endtask

    task automatic prog_lock(input logic [3:0] m);
        @(negedge clk);
        mode_sel = m;
        hv_en = 1'b1;
        @(negedge clk);
        prog_n = 1'b0;
        @(negedge clk);
        check(rdy === 1'b0, "R10", "rdy during lock write", {15'd0, rdy}, 16'h0);
        @(negedge clk);
        prog_n = 1'b1;
        repeat (W + 4) @(negedge clk);
        check(rdy === 1'b1, "R10", "rdy after lock write", {15'd0, rdy}, 16'h1);
        mode_sel = M_IDLE;
    endtask

    task automatic t_reset;
        check(rdy === 1'b1, "R12", "rdy after reset", {15'd0, rdy}, 16'h1);
        check(data_out === 8'h00, "R12", "data_out after reset", {8'd0, data_out}, 16'h0);
        check(data_oe === 1'b0, "R9", "data_oe in idle mode", {15'd0, data_oe}, 16'h0);
    endtask

    task automatic t_first_erase;
        logic [7:0] d;
        do_erase(E + 5);
        read_byte(M_VER, 12'h000, d);
        check(d === 8'hFF, "R7", "erased byte 000", {8'd0, d}, 16'hFF);
        read_byte(M_VER, 12'hFFF, d);
        check(d === 8'hFF, "R7", "erased byte FFF", {8'd0, d}, 16'hFF);
    endtask

    // Byte write with exact busy window, polling value, and address split.
    task automatic t_write_timing;
        logic [7:0] d;
        @(negedge clk);
        mode_sel = M_WR;
        set_addr(12'hA5C);
        data_in = 8'h5A;
        hv_en = 1'b1;
        @(negedge clk);
        prog_n = 1'b0;
        @(negedge clk);                           // edge 1 sampled the pulse
        check(rdy === 1'b0, "R3", "rdy after first low edge", {15'd0, rdy}, 16'h0);
        @(negedge clk);                           // edge 2
        @(negedge clk);                           // edge 3
        prog_n = 1'b1;
        mode_sel = M_VER;
        @(negedge clk);                           // edge 4: poll registered
        check(data_out[7] === 1'b1, "R6", "poll bit7 while busy", {15'd0, data_out[7]}, 16'h1);
        repeat (W - 4) @(negedge clk);            // edge W: last busy cycle
        check(rdy === 1'b0, "R3", "rdy on last busy cycle", {15'd0, rdy}, 16'h0);
        @(negedge clk);                           // edge W+1: ready
        check(rdy === 1'b1, "R3", "rdy after write cycle", {15'd0, rdy}, 16'h1);
        @(negedge clk);
        check(data_out === 8'h5A, "R2", "written byte A5C", {8'd0, data_out}, 16'h5A);
        read_byte(M_VER, 12'h05C, d);
        check(d === 8'hFF, "R1", "same low byte, other high nibble", {8'd0, d}, 16'hFF);
        read_byte(M_VER, 12'hA5D, d);
        check(d === 8'hFF, "R1", "neighbouring address", {8'd0, d}, 16'hFF);
    endtask

    task automatic t_and;
        logic [7:0] d;
        write_byte(12'h020, 8'hF0);
        write_byte(12'h020, 8'h3C);
        read_byte(M_VER, 12'h020, d);
        check(d === 8'h30, "R2", "second write ANDs into byte", {8'd0, d}, 16'h30);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] d;
        @(negedge clk);
        mode_sel = M_WR;
        set_addr(12'h100);
        data_in = 8'h0F;
        @(negedge clk);
        prog_n = 1'b0;
        @(negedge clk);                           // edge 1
        @(negedge clk);                           // edge 2
        prog_n = 1'b1;
        @(negedge clk);                           // edge 3
        set_addr(12'h101);
        data_in = 8'h00;
        @(negedge clk);                           // edge 4
        prog_n = 1'b0;
        @(negedge clk);                           // edge 5: ignored fall
        @(negedge clk);                           // edge 6
        prog_n = 1'b1;
        repeat (W - 6) @(negedge clk);            // edge W
        check(rdy === 1'b0, "R4", "busy window not extended (last)", {15'd0, rdy}, 16'h0);
        @(negedge clk);
        check(rdy === 1'b1, "R4", "ready at original end", {15'd0, rdy}, 16'h1);
        repeat (W + 4) @(negedge clk);
        read_byte(M_VER, 12'h101, d);
        check(d === 8'hFF, "R4", "pulse while busy wrote nothing", {8'd0, d}, 16'hFF);
        read_byte(M_VER, 12'h100, d);
        check(d === 8'h0F, "R4", "first write intact", {8'd0, d}, 16'h0F);
    endtask

    task automatic t_hv;
        logic [7:0] d;
        @(negedge clk);
        mode_sel = M_WR;
        set_addr(12'h200);
        data_in = 8'h00;
        hv_en = 1'b0;
        @(negedge clk);
        prog_n = 1'b0;
        @(negedge clk);
        check(rdy === 1'b1, "R5", "no busy without hv_en", {15'd0, rdy}, 16'h1);
        @(negedge clk);
        prog_n = 1'b1;
        repeat (W + 4) @(negedge clk);
        hv_en = 1'b1;
        read_byte(M_VER, 12'h200, d);
        check(d === 8'hFF, "R5", "no write without hv_en", {8'd0, d}, 16'hFF);
    endtask

    task automatic t_signature;
        logic [7:0] d;
        read_byte(M_SIG, 12'h030, d);
        check(d === 8'h1E, "R8", "signature 030", {8'd0, d}, 16'h1E);
        check(data_oe === 1'b1, "R9", "data_oe in signature mode", {15'd0, data_oe}, 16'h1);
        read_byte(M_SIG, 12'h031, d);
        check(d === 8'h51, "R8", "signature 031", {8'd0, d}, 16'h51);
        read_byte(M_SIG, 12'h032, d);
        check(d === 8'hFF, "R8", "signature 032 high-voltage", {8'd0, d}, 16'hFF);
        read_byte(M_SIG, 12'h033, d);
        check(d === 8'hFF, "R8", "non-signature address", {8'd0, d}, 16'hFF);
        @(negedge clk);
        mode_sel = M_IDLE;
        #1;
        check(data_oe === 1'b0, "R9", "data_oe back in idle", {15'd0, data_oe}, 16'h0);
    endtask

    task automatic t_short_erase;
        logic [7:0] d;
        do_erase(E / 2);
        read_byte(M_VER, 12'h020, d);
        check(d === 8'h30, "R7", "short erase pulse ignored", {8'd0, d}, 16'h30);
    endtask

    task automatic t_lock2;
        logic [7:0] d;
        prog_lock(M_L2);
        read_byte(M_VER, 12'h020, d);
        check(d === 8'hFF, "R9", "verify hidden by lock 2", {8'd0, d}, 16'hFF);
        read_byte(M_SIG, 12'h031, d);
        check(d === 8'h51, "R8", "signature readable when locked", {8'd0, d}, 16'h51);
    endtask

    task automatic t_ea;
        @(negedge clk);
        ext_access = 1'b1;
        #1;
        check(ea_out === 1'b1, "R11", "ea follows strap high (unlocked)", {15'd0, ea_out}, 16'h1);
        @(negedge clk);
        ext_access = 1'b0;
        #1;
        check(ea_out === 1'b0, "R11", "ea follows strap low (unlocked)", {15'd0, ea_out}, 16'h0);
        prog_lock(M_L1);
        @(negedge clk);
        ext_access = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ext_access = 1'b0;
        @(negedge clk);
        check(ea_out === 1'b1, "R11", "ea latched at reset with lock 1", {15'd0, ea_out}, 16'h1);
        check(rdy === 1'b1, "R12", "rdy after second reset", {15'd0, rdy}, 16'h1);
    endtask

    task automatic t_full_erase;
        logic [7:0] d;
        do_erase(E + 5);
        #1;
        check(ea_out === 1'b0, "R7", "lock 1 cleared by erase", {15'd0, ea_out}, 16'h0);
        read_byte(M_VER, 12'hA5C, d);
        check(d === 8'hFF, "R7", "byte erased, locks cleared", {8'd0, d}, 16'hFF);
        write_byte(12'h020, 8'h77);
        read_byte(M_VER, 12'h020, d);
        check(d === 8'h77, "R9", "verify visible after unlock", {8'd0, d}, 16'h77);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_erase();
        t_write_timing();
        t_and();
        t_busy_ignore();
        t_hv();
        t_signature();
        t_short_erase();
        t_lock2();
        t_ea();
        t_full_erase();
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule